// File: doc/BRIEF.md
# GPIO Interrupt Front-End

This block sits between a bank of general-purpose input lines and a single interrupt request pin of a CPU interrupt controller. Each line is first brought into the local clock domain by a two-flop synchroniser. It then passes through four per-line settings: enable, mask, trigger type (level or edge) and polarity. The results are gathered into a raw status word and a masked status word, and one combined request is driven out. Software configures and services the block through a plain 32-bit register bus: a write strobe with address and data, and a read data word that is a combinational function of the address.

Enable and mask are separate controls. A line that is enabled but masked still records its events in raw status, but it cannot reach the output. This lets software poll a line without taking interrupts from it. Edge events stay latched until software acknowledges them through a write-one-to-clear register. Level events follow the synchronised input directly.

Register offsets (byte addresses): enable 0x30, mask 0x34, trigger type 0x38, polarity 0x3c, masked status 0x40 (read-only), raw status 0x44 (read-only), end-of-interrupt 0x4c (write-only, reads 0). Any other address reads 0 and ignores writes.

Top module: `gpio_irq_front`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is low, so all lines are disabled, unmasked, edge-triggered and active-low.
- R2: A line whose enable bit (0x30) is 0 never shows a 1 in raw status (0x44) or masked status (0x40), and never raises `irq_o`, whatever its input does.
- R3: A mask bit (0x34) of 1 forces that line's masked status bit to 0 and keeps it off `irq_o`; its raw status bit is unaffected. A mask bit of 0 lets the raw bit through.
- R4: With trigger-type bit (0x38) = 1 the line is level-sensitive. Its raw status bit equals the synchronised input when the polarity bit (0x3c) is 1, and the inverted input when the polarity bit is 0.
- R5: With trigger-type bit = 0 the line is edge-triggered. A rising edge (polarity 1) or falling edge (polarity 0) sets the raw status bit. The bit stays set after the input returns.
- R6: Writing 1 to a bit of the end-of-interrupt register (0x4c) clears that line's latched edge event. Bits written as 0 leave their lines unchanged, and the register reads back 0.
- R7: `irq_o` is high exactly when the masked status word is non-zero.
- R8: The enable, mask, trigger-type and polarity registers read back the last value written to them.
- R9: A change on an input reaches level-mode raw status after exactly two rising clock edges. An edge event shows in raw status after exactly three.
- R10: With a single line (for example line 12) enabled and every other line masked, only that line can set `irq_o`, while activity on the other lines leaves `irq_o` low.
- R11: Clearing a line's enable bit, or switching it to level mode, discards any edge event latched for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_in | input | NLINES (32) | Asynchronous input lines |
| bus_we | input | 1 | Register write strobe, one write per cycle it is high |
| bus_addr | input | ADDR_W (8) | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Combined interrupt request, high when any masked status bit is set |

## Verification
The bench goes after the cases where the per-line controls interact. It drives inputs on lines that are masked but enabled: a design that gated raw status with the mask would hide those events from polling. It drives inputs on lines that are enabled but disabled-by-mask, and on lines that are unmasked but disabled: a design that confused enable and mask would raise `irq_o` in one of them. Edge latches are tested for persistence, for a selective end-of-interrupt clear (a design that cleared the whole word would lose pending lines) and for being discarded on disable. The synchroniser latency is counted edge by edge, so an extra or missing flop shifts the result by one cycle and is caught. Random configurations with active-high and active-low, level and edge lines mixed expose any polarity inversion.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned BUS_W = 32;

  localparam logic [7:0] OFS_ENABLE  = 8'h30;
  localparam logic [7:0] OFS_MASK    = 8'h34;
  localparam logic [7:0] OFS_TRIGGER = 8'h38;
  localparam logic [7:0] OFS_POLAR   = 8'h3c;
  localparam logic [7:0] OFS_MSTAT   = 8'h40;
  localparam logic [7:0] OFS_RSTAT   = 8'h44;
  localparam logic [7:0] OFS_EOI     = 8'h4c;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ENABLE,
    SEL_MASK,
    SEL_TRIGGER,
    SEL_POLAR,
    SEL_MSTAT,
    SEL_RSTAT,
    SEL_EOI
  } reg_sel_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_line.sv
module gpio_irq_line (
  input  logic clk,
  input  logic rst_n,
  input  logic in_s,
  input  logic en,
  input  logic lvl_mode,
  input  logic act_high,
  input  logic eoi_clr,
  output logic hit,
  output logic latch_q,
  output logic raw
);
  logic prev_q;
  logic act_now;
  logic act_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= in_s;
  end

  assign act_now  = ~(in_s ^ act_high);
  assign act_prev = ~(prev_q ^ act_high);
  assign hit      = en & ~lvl_mode & act_now & ~act_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                latch_q <= 1'b0;
    else if (!en || lvl_mode)  latch_q <= 1'b0;
    else if (hit)              latch_q <= 1'b1;
    else if (eoi_clr)          latch_q <= 1'b0;
  end

  assign raw = en & (lvl_mode ? act_now : latch_q);
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NLINES = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [NLINES-1:0] raw_stat,
  output logic [NLINES-1:0] en_q,
  output logic [NLINES-1:0] mask_q,
  output logic [NLINES-1:0] lvl_q,
  output logic [NLINES-1:0] pol_q,
  output logic [NLINES-1:0] msk_stat,
  output logic [NLINES-1:0] eoi_clr
);
  reg_sel_e sel;
  logic [BUS_W-1:0] rd_mux;

  function automatic logic [BUS_W-1:0] widen(input logic [NLINES-1:0] v);
    logic [BUS_W-1:0] r;
    r = '0;
    r[NLINES-1:0] = v;
    return r;
  endfunction

  always_comb begin
    sel = SEL_NONE;
    if      (bus_addr == ADDR_W'(OFS_ENABLE))  sel = SEL_ENABLE;
    else if (bus_addr == ADDR_W'(OFS_MASK))    sel = SEL_MASK;
    else if (bus_addr == ADDR_W'(OFS_TRIGGER)) sel = SEL_TRIGGER;
    else if (bus_addr == ADDR_W'(OFS_POLAR))   sel = SEL_POLAR;
    else if (bus_addr == ADDR_W'(OFS_MSTAT))   sel = SEL_MSTAT;
    else if (bus_addr == ADDR_W'(OFS_RSTAT))   sel = SEL_RSTAT;
    else if (bus_addr == ADDR_W'(OFS_EOI))     sel = SEL_EOI;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mask_q <= '0;
      lvl_q  <= '0;
      pol_q  <= '0;
    end else if (bus_we) begin
      unique case (sel)
        SEL_ENABLE:  en_q   <= bus_wdata[NLINES-1:0];
        SEL_MASK:    mask_q <= bus_wdata[NLINES-1:0];
        SEL_TRIGGER: lvl_q  <= bus_wdata[NLINES-1:0];
        SEL_POLAR:   pol_q  <= bus_wdata[NLINES-1:0];
        default: ;
      endcase
    end
  end

  assign eoi_clr  = (bus_we && sel == SEL_EOI) ? bus_wdata[NLINES-1:0] : '0;
  assign msk_stat = raw_stat & ~mask_q;

  always_comb begin
    unique case (sel)
      SEL_ENABLE:  rd_mux = widen(en_q);
      SEL_MASK:    rd_mux = widen(mask_q);
      SEL_TRIGGER: rd_mux = widen(lvl_q);
      SEL_POLAR:   rd_mux = widen(pol_q);
      SEL_MSTAT:   rd_mux = widen(msk_stat);
      SEL_RSTAT:   rd_mux = widen(raw_stat);
      default:     rd_mux = '0;
    endcase
  end

  assign bus_rdata = rd_mux;
endmodule

// File: rtl/gpio_irq_front.sv
module gpio_irq_front
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NLINES = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] gpio_in,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq_o
);
  logic [NLINES-1:0] in_s;
  logic [NLINES-1:0] en_q, mask_q, lvl_q, pol_q;
  logic [NLINES-1:0] raw_stat, msk_stat, eoi_clr;
  logic [NLINES-1:0] hit, latch_q;

  gpio_irq_sync #(.WIDTH(NLINES), .STAGES(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (gpio_in),
    .sync_o  (in_s)
  );

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    gpio_irq_line u_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_s     (in_s[i]),
      .en       (en_q[i]),
      .lvl_mode (lvl_q[i]),
      .act_high (pol_q[i]),
      .eoi_clr  (eoi_clr[i]),
      .hit      (hit[i]),
      .latch_q  (latch_q[i]),
      .raw      (raw_stat[i])
    );
  end

  gpio_irq_regs #(.NLINES(NLINES), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .raw_stat  (raw_stat),
    .en_q      (en_q),
    .mask_q    (mask_q),
    .lvl_q     (lvl_q),
    .pol_q     (pol_q),
    .msk_stat  (msk_stat),
    .eoi_clr   (eoi_clr)
  );

  assign irq_o = |msk_stat;
endmodule

// File: rtl/gpio_irq_front_chk.sv
module gpio_irq_front_chk #(
  parameter int unsigned NLINES = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_o,
  input logic [NLINES-1:0] en_q,
  input logic [NLINES-1:0] mask_q,
  input logic [NLINES-1:0] lvl_q,
  input logic [NLINES-1:0] raw_stat,
  input logic [NLINES-1:0] msk_stat,
  input logic [NLINES-1:0] eoi_clr,
  input logic [NLINES-1:0] hit,
  input logic [NLINES-1:0] latch_q
);
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_stat & ~en_q) == '0); // R2

  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_stat & mask_q) == '0); // R3

  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (msk_stat != '0)); // R7

  AST_STATUS_DRIVES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_stat != '0) |-> irq_o); // R7

  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(latch_q) & ~latch_q) & ~$past(eoi_clr | ~en_q | lvl_q)) == '0); // R5

  AST_HIT_SETS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> (($past(hit) & ~latch_q & en_q & ~lvl_q) == '0)); // R5

  AST_DISABLE_DISCARDS: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q & ($past(~en_q | lvl_q))) == '0); // R11
endmodule

bind gpio_irq_front gpio_irq_front_chk #(.NLINES(NLINES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq_o    (irq_o),
  .en_q     (en_q),
  .mask_q   (mask_q),
  .lvl_q    (lvl_q),
  .raw_stat (raw_stat),
  .msk_stat (msk_stat),
  .eoi_clr  (eoi_clr),
  .hit      (hit),
  .latch_q  (latch_q)
);

// File: tb/gpio_irq_front_tb.sv
module gpio_irq_front_tb_top;
  localparam int unsigned N = 32;
  localparam logic [7:0] A_EN = 8'h30, A_MK = 8'h34, A_TY = 8'h38, A_PO = 8'h3c;
  localparam logic [7:0] A_MS = 8'h40, A_RS = 8'h44, A_EOI = 8'h4c;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] gpio_in = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_irq_front dut_i (
    .clk(clk), .rst_n(rst_n), .gpio_in(gpio_in), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  function automatic logic [31:0] act_of(input logic [31:0] v, input logic [31:0] pol);
    return ~(v ^ pol);
  endfunction

  function automatic logic [31:0] exp_raw(input logic [31:0] en, input logic [31:0] ty,
      input logic [31:0] pol, input logic [31:0] v_old, input logic [31:0] v_new);
    logic [31:0] a_new, a_old;
    a_new = act_of(v_new, pol);
    a_old = act_of(v_old, pol);
    return en & ((ty & a_new) | (~ty & a_new & ~a_old));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    ticks(3);
    // R1 reset state
    foreach (A_EN[i]) ; // no-op
    rd(A_EN, d); check("R1 enable", d, 0);
    rd(A_MK, d); check("R1 mask", d, 0);
    rd(A_TY, d); check("R1 type", d, 0);
    rd(A_PO, d); check("R1 polarity", d, 0);
    rst_n = 1'b1;
    ticks(2);
    rd(A_RS, d); check("R1 raw", d, 0);
    check("R1 irq", {31'b0, irq_o}, 0);

    // R8 readback
    wr(A_EN, 32'hA5A5_0F0F); rd(A_EN, d); check("R8 enable", d, 32'hA5A5_0F0F);
    wr(A_MK, 32'h1234_5678); rd(A_MK, d); check("R8 mask", d, 32'h1234_5678);
    wr(A_TY, 32'hFFFF_0000); rd(A_TY, d); check("R8 type", d, 32'hFFFF_0000);
    wr(A_PO, 32'h0F0F_F0F0); rd(A_PO, d); check("R8 polarity", d, 32'h0F0F_F0F0);
    wr(A_EOI, 32'hFFFF_FFFF); rd(A_EOI, d); check("R6 eoi reads 0", d, 0);

    // R9 level latency: line 0 level, active high
    wr(A_EN, 32'h1); wr(A_MK, 0); wr(A_TY, 32'h1); wr(A_PO, 32'h1);
    gpio_in = '0; ticks(4);
    gpio_in[0] = 1'b1;
    ticks(1); rd(A_RS, d); check("R9 level after 1 edge", d, 0);
    ticks(1); rd(A_RS, d); check("R9 level after 2 edges", d, 1);
    check("R4 level high irq", {31'b0, irq_o}, 1);
    // R4 active low
    wr(A_PO, 0); ticks(1); rd(A_RS, d); check("R4 active-low input high", d, 0);
    gpio_in[0] = 1'b0; ticks(2); rd(A_RS, d); check("R4 active-low input low", d, 1);

    // R9 edge latency + R5 persistence, line 3 rising
    wr(A_TY, 0); wr(A_PO, 32'h8); wr(A_EN, 32'h8); gpio_in = '0; ticks(4);
    wr(A_EOI, 32'hFFFF_FFFF);
    gpio_in[3] = 1'b1;
    ticks(2); rd(A_RS, d); check("R9 edge after 2 edges", d, 0);
    ticks(1); rd(A_RS, d); check("R9 edge after 3 edges", d, 32'h8);
    gpio_in[3] = 1'b0; ticks(4); rd(A_RS, d); check("R5 edge held", d, 32'h8);
    // R6 selective EOI
    wr(A_EOI, 32'hFFFF_FFF7); rd(A_RS, d); check("R6 zero bits no effect", d, 32'h8);
    wr(A_EOI, 32'h8); rd(A_RS, d); check("R6 clear", d, 0);
    check("R7 irq low after clear", {31'b0, irq_o}, 0);
    // R5 falling edge polarity 0
    wr(A_PO, 0); gpio_in[3] = 1'b1; ticks(4); wr(A_EOI, 32'hFFFF_FFFF);
    gpio_in[3] = 1'b0; ticks(4); rd(A_RS, d); check("R5 falling edge", d, 32'h8);
    // R11 disable discards
    wr(A_EN, 0); wr(A_EN, 32'h8); rd(A_RS, d); check("R11 disable discards", d, 0);

    // R3 masked but enabled: raw visible, masked/irq blocked
    wr(A_PO, 32'hFFFF_FFFF); wr(A_TY, 32'hFFFF_FFFF); wr(A_EN, 32'h20); wr(A_MK, 32'h20);
    gpio_in = 32'h20; ticks(3);
    rd(A_RS, d); check("R3 raw unaffected", d, 32'h20);
    rd(A_MS, d); check("R3 masked blocked", d, 0);
    check("R3 irq blocked", {31'b0, irq_o}, 0);
    // R2 disabled unmasked
    wr(A_EN, 0); wr(A_MK, 0); gpio_in = 32'hFFFF_FFFF; ticks(3);
    rd(A_RS, d); check("R2 disabled raw", d, 0);
    check("R2 disabled irq", {31'b0, irq_o}, 0);

    // R10 single line 12
    wr(A_TY, 0); wr(A_PO, 32'hFFFF_FFFF); wr(A_MK, ~(32'h1 << 12)); wr(A_EN, 32'hFFFF_FFFF);
    gpio_in = '0; ticks(4); wr(A_EOI, 32'hFFFF_FFFF);
    gpio_in = ~(32'h1 << 12); ticks(4);
    check("R10 others quiet", {31'b0, irq_o}, 0);
    rd(A_MS, d); check("R10 masked others", d, 0);
    gpio_in = 32'hFFFF_FFFF; ticks(4);
    check("R10 line 12 fires", {31'b0, irq_o}, 1);
    rd(A_MS, d); check("R10 masked line 12", d, 32'h1000);

    // random phase
    void'($urandom(32'h5eed_1234));
    for (int it = 0; it < 60; it++) begin
      logic [31:0] en, mk, ty, po, vo, vn, er;
      en = $urandom; mk = $urandom; ty = $urandom; po = $urandom;
      vo = $urandom; vn = (it % 4 == 0) ? vo : $urandom;
      gpio_in = vo;
      wr(A_EN, en); wr(A_MK, mk); wr(A_TY, ty); wr(A_PO, po);
      ticks(4);
      wr(A_EOI, 32'hFFFF_FFFF);
      gpio_in = vn; ticks(4);
      er = exp_raw(en, ty, po, vo, vn);
      rd(A_RS, d); check("R4 R5 random raw", d, er);
      rd(A_MS, d); check("R3 random masked", d, er & ~mk);
      check("R7 random irq", {31'b0, irq_o}, {31'b0, |(er & ~mk)});
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule